// File: doc/BRIEF.md
# NAND Erase-Block Factory Bad-Marker Checker

This block decides whether one erase block of a NAND flash device carries a factory bad-block mark. Give it a block number and a configuration, then pulse `startReq`. The block asks an external page-read port for the spare-area marker byte of one or more pages in that block. It judges each byte by counting its set bits, and it ends with a one-cycle `done` pulse carrying a bad flag and a read-error flag.

Three independent enables choose which pages to inspect: the first page, the second page and the last page of the block. The selected pages are read in that order, and checking stops at the first marker that fails. The spare-area column holding the marker depends on the page-size class. A quirk input skips all reads and reports the block good. This input is for controllers whose ECC layout overwrites the marker.

Top module: `bbm_checker`

## Requirements
- R1: After reset `done`, `busy`, `rdReq`, `isBad` and `rdErrFlag` are all 0.
- R2: The column on `rdCol` is 5 when `largePage` is 0 (small pages) and 0 when `largePage` is 1.
- R3: The first page of block B is B × PAGES_PER_BLOCK. The second page is that value + 1, and the last page is that value + PAGES_PER_BLOCK − 1. PAGES_PER_BLOCK is a power of two, at least 4.
- R4: The selected pages are read in the order first (`chkFirst`), second (`chkSecond`), last (`chkLast`). When every marker is good, each selected page is read exactly once.
- R5: When none of the three enables is set, only the first page is read.
- R6: A marker byte is good when its number of 1 bits is greater than or equal to `threshold`. For example, 8'hF7 is good at threshold 7 and bad at threshold 8, and every byte is good at threshold 0.
- R7: The first bad marker ends the check with `isBad`=1. No further page is requested.
- R8: With `noBbmQuirk`=1 at the start, no read is requested. `done` rises one cycle after the start with `isBad`=0, and `busy` stays 0.
- R9: A response with `rdErr`=1 ends the check with `isBad`=1 and `rdErrFlag`=1, whatever byte accompanies it. When no response carries `rdErr`=1, `rdErrFlag` is 0.
- R10: `done` is high for exactly one cycle. `isBad` and `rdErrFlag` are valid with it and hold until the next accepted start.
- R11: A start is accepted only while `busy` is 0. Configuration inputs are captured at the accepted start; later changes, and starts while busy, have no effect on the run in progress.
- R12: `rdReq` stays high with `rdPage` and `rdCol` stable until `rdAck`. It is low for at least one cycle between two requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start a check (accepted when not busy) |
| blockNum | input | BLOCK_W | Erase block to check |
| largePage | input | 1 | 1 = large-page device, 0 = small-page device |
| chkFirst | input | 1 | Inspect the block's first page |
| chkSecond | input | 1 | Inspect the block's second page |
| chkLast | input | 1 | Inspect the block's last page |
| threshold | input | THR_W | Minimum count of 1 bits for a good marker |
| noBbmQuirk | input | 1 | Skip marker reads and report good |
| rdReq | output | 1 | Page-read request |
| rdPage | output | BLOCK_W+log2(PAGES_PER_BLOCK) | Page number being requested |
| rdCol | output | COL_W | Spare-area column of the marker byte |
| rdAck | input | 1 | One-cycle response strobe |
| rdByte | input | MARKER_W | Marker byte returned with `rdAck` |
| rdErr | input | 1 | Response reports a read failure |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| isBad | output | 1 | Block judged bad |
| rdErrFlag | output | 1 | Check ended because of a read error |

## Verification
A single response can carry a read error and a marker byte at the same time. The byte alone could be judged good or bad, so two outcomes compete in one cycle. The bench sends error responses with an all-zero byte and with an all-ones byte, on the first and on the second selected page. In every case it expects the error to win, with both flags set and no later request. A second collision is a start presented in the same cycles as an active run: some runs keep `startReq` high and scramble the configuration during the whole check. The bench expects the page sequence and the verdict of the captured configuration.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_STEP
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic retirePage;
  } dpStrobe_t;

  // bit positions of the page-selection mask; order is the read priority
  localparam int SEL_FIRST  = 0;
  localparam int SEL_SECOND = 1;
  localparam int SEL_LAST   = 2;
  localparam int SEL_N      = 3;

endpackage

// File: rtl/bbm_ones_count.sv
module bbm_ones_count #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  dataIn,
  output logic [CW-1:0] onesOut
);

  always_comb begin
    onesOut = '0;
    for (int i = 0; i < W; i++) begin
      onesOut = onesOut + {{(CW-1){1'b0}}, dataIn[i]};
    end
  end

endmodule

// File: rtl/bbm_datapath.sv
module bbm_datapath
  import bbm_pkg::*;
#(
  parameter int BLOCK_W   = 12,
  parameter int PPB       = 64,
  parameter int MARKER_W  = 8,
  parameter int COL_W     = 6,
  parameter int SMALL_COL = 5,
  parameter int LARGE_COL = 0,
  localparam int PPB_SHIFT = $clog2(PPB),
  localparam int PAGE_W    = BLOCK_W + PPB_SHIFT,
  localparam int THR_W     = $clog2(MARKER_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [BLOCK_W-1:0]  blockNum,
  input  logic                largePage,
  input  logic                chkFirst,
  input  logic                chkSecond,
  input  logic                chkLast,
  input  logic [THR_W-1:0]    threshold,
  input  logic [MARKER_W-1:0] rdByte,
  output logic [PAGE_W-1:0]   rdPage,
  output logic [COL_W-1:0]    rdCol,
  output logic                markerOk,
  output logic                lastPending
);

  localparam int unsigned LAST_I = PPB - 1;
  localparam logic [PPB_SHIFT-1:0] FIRST_OFS  = '0;
  localparam logic [PPB_SHIFT-1:0] SECOND_OFS = {{(PPB_SHIFT-1){1'b0}}, 1'b1};
  localparam logic [PPB_SHIFT-1:0] LAST_OFS   = LAST_I[PPB_SHIFT-1:0];
  localparam int unsigned SMALL_U = SMALL_COL;
  localparam int unsigned LARGE_U = LARGE_COL;
  localparam logic [COL_W-1:0] SMALL_C = SMALL_U[COL_W-1:0];
  localparam logic [COL_W-1:0] LARGE_C = LARGE_U[COL_W-1:0];

  logic [BLOCK_W-1:0]   blockReg;
  logic                 largeReg;
  logic [THR_W-1:0]     thrReg;
  logic [SEL_N-1:0]     maskReg;
  logic [SEL_N-1:0]     maskLoad;
  logic [PPB_SHIFT-1:0] pageOfs;
  logic [THR_W-1:0]     onesCnt;

  always_comb begin
    maskLoad = '0;
    maskLoad[SEL_FIRST]  = chkFirst;
    maskLoad[SEL_SECOND] = chkSecond;
    maskLoad[SEL_LAST]   = chkLast;
    if (maskLoad == '0) maskLoad[SEL_FIRST] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockReg <= '0;
      largeReg <= 1'b0;
      thrReg   <= '0;
      maskReg  <= '0;
    end else if (strobe.loadCfg) begin
      blockReg <= blockNum;
      largeReg <= largePage;
      thrReg   <= threshold;
      maskReg  <= maskLoad;
    end else if (strobe.retirePage) begin
      maskReg  <= maskReg & (maskReg - 1'b1);
    end
  end

  // lowest pending selection picks the page
  always_comb begin
    if (maskReg[SEL_FIRST])       pageOfs = FIRST_OFS;
    else if (maskReg[SEL_SECOND]) pageOfs = SECOND_OFS;
    else                          pageOfs = LAST_OFS;
  end

  assign rdPage      = {blockReg, pageOfs};
  assign rdCol       = largeReg ? LARGE_C : SMALL_C;
  assign lastPending = ($countones(maskReg) <= 1);

  bbm_ones_count #(.W(MARKER_W), .CW(THR_W)) uOnes (
    .dataIn  (rdByte),
    .onesOut (onesCnt)
  );

  assign markerOk = (onesCnt >= thrReg);

  p_retire_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retirePage |=> ($countones(maskReg) == $past($countones(maskReg)) - 1));

  p_mask_loaded_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCfg |=> (maskReg != '0));

endmodule

// File: rtl/bbm_ctrl.sv
module bbm_ctrl
  import bbm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      noBbmQuirk,
  input  logic      rdAck,
  input  logic      rdErr,
  input  logic      markerOk,
  input  logic      lastPending,
  output dpStrobe_t strobe,
  output logic      rdReq,
  output logic      busy,
  output logic      done,
  output logic      isBad,
  output logic      rdErrFlag
);

  ctrlState_e state;

  always_comb begin
    strobe.loadCfg    = (state == ST_IDLE) && startReq;
    strobe.retirePage = (state == ST_REQ) && rdAck && !rdErr && markerOk && !lastPending;
  end

  assign rdReq = (state == ST_REQ);
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      isBad     <= 1'b0;
      rdErrFlag <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            isBad     <= 1'b0;
            rdErrFlag <= 1'b0;
            if (noBbmQuirk) done  <= 1'b1;
            else            state <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rdAck) begin
            if (rdErr) begin
              done      <= 1'b1;
              isBad     <= 1'b1;
              rdErrFlag <= 1'b1;
              state     <= ST_IDLE;
            end else if (!markerOk) begin
              done  <= 1'b1;
              isBad <= 1'b1;
              state <= ST_IDLE;
            end else if (lastPending) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_STEP;
            end
          end
        end
        ST_STEP: state <= ST_REQ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_err_bad_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdErrFlag |-> isBad);

  p_quirk_fast_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq && noBbmQuirk) |=> (done && !isBad && !busy));

  p_fail_stops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck && !rdErr && !markerOk) |=> (done && isBad && !rdReq));

  p_req_gap_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck) |=> !rdReq);

endmodule

// File: rtl/bbm_checker.sv
module bbm_checker
  import bbm_pkg::*;
#(
  parameter int BLOCK_W   = 12,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MARKER_W  = 8,
  parameter int COL_W     = 6,
  parameter int SMALL_COL = 5,
  parameter int LARGE_COL = 0,
  localparam int PAGE_W   = BLOCK_W + $clog2(PAGES_PER_BLOCK),
  localparam int THR_W    = $clog2(MARKER_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [BLOCK_W-1:0]  blockNum,
  input  logic                largePage,
  input  logic                chkFirst,
  input  logic                chkSecond,
  input  logic                chkLast,
  input  logic [THR_W-1:0]    threshold,
  input  logic                noBbmQuirk,
  output logic                rdReq,
  output logic [PAGE_W-1:0]   rdPage,
  output logic [COL_W-1:0]    rdCol,
  input  logic                rdAck,
  input  logic [MARKER_W-1:0] rdByte,
  input  logic                rdErr,
  output logic                busy,
  output logic                done,
  output logic                isBad,
  output logic                rdErrFlag
);

  dpStrobe_t strobe;
  logic      markerOk;
  logic      lastPending;

  bbm_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .noBbmQuirk  (noBbmQuirk),
    .rdAck       (rdAck),
    .rdErr       (rdErr),
    .markerOk    (markerOk),
    .lastPending (lastPending),
    .strobe      (strobe),
    .rdReq       (rdReq),
    .busy        (busy),
    .done        (done),
    .isBad       (isBad),
    .rdErrFlag   (rdErrFlag)
  );

  bbm_datapath #(
    .BLOCK_W   (BLOCK_W),
    .PPB       (PAGES_PER_BLOCK),
    .MARKER_W  (MARKER_W),
    .COL_W     (COL_W),
    .SMALL_COL (SMALL_COL),
    .LARGE_COL (LARGE_COL)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .blockNum    (blockNum),
    .largePage   (largePage),
    .chkFirst    (chkFirst),
    .chkSecond   (chkSecond),
    .chkLast     (chkLast),
    .threshold   (threshold),
    .rdByte      (rdByte),
    .rdPage      (rdPage),
    .rdCol       (rdCol),
    .markerOk    (markerOk),
    .lastPending (lastPending)
  );

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdPage) && $stable(rdCol)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdReq);

endmodule

// File: tb/bbm_checker_test.sv
module bbm_checker_test;

  localparam int BW  = 6;
  localparam int PPB = 16;
  localparam int PW  = BW + 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [BW-1:0] blockNum = '0;
  logic          largePage = 1'b0;
  logic          chkFirst = 1'b0, chkSecond = 1'b0, chkLast = 1'b0;
  logic [3:0]    threshold = '0;
  logic          noBbmQuirk = 1'b0;
  logic          rdReq;
  logic [PW-1:0] rdPage;
  logic [5:0]    rdCol;
  logic          rdAck = 1'b0;
  logic [7:0]    rdByte = '0;
  logic          rdErr = 1'b0;
  logic          busy, done, isBad, rdErrFlag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  bbm_checker #(.BLOCK_W(BW), .PAGES_PER_BLOCK(PPB)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .blockNum(blockNum),
    .largePage(largePage), .chkFirst(chkFirst), .chkSecond(chkSecond),
    .chkLast(chkLast), .threshold(threshold), .noBbmQuirk(noBbmQuirk),
    .rdReq(rdReq), .rdPage(rdPage), .rdCol(rdCol), .rdAck(rdAck),
    .rdByte(rdByte), .rdErr(rdErr), .busy(busy), .done(done),
    .isBad(isBad), .rdErrFlag(rdErrFlag)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired (R1..R12 run hung) actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int actual, input int expected);
    checks = checks + 1;
    if (actual != expected) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int ones(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    return n;
  endfunction

  function automatic logic [7:0] patByte(input int pat, input int k, input int blk);
    case (pat)
      0: return 8'hFF;
      1: return 8'hF7;
      2: return (k == 1) ? 8'h0F : 8'hFF;
      3: return (k == 1) ? 8'h00 : 8'hFF;
      4: return 8'((blk * 37 + k * 91 + 200) & 255);
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit patErr(input int pat, input int k);
    return (pat == 3 && k == 1) || (pat == 5 && k == 0);
  endfunction

  task automatic runCase(input int blk, input bit lg, input bit [2:0] flags,
                         input int thr, input bit quirk, input int pat, input bit poke);
    int expPg[3];
    int n = 0;
    int expReads = 0;
    bit expBad = 0, expErr = 0;
    int reads = 0;
    bit seenDone = 0;
    int guard = 0;
    int lat;
    // R3 R4 R5: expected page order
    if (flags[0] || flags == 3'b000) begin expPg[n] = blk * PPB; n++; end
    if (flags[1]) begin expPg[n] = blk * PPB + 1; n++; end
    if (flags[2]) begin expPg[n] = blk * PPB + PPB - 1; n++; end
    if (!quirk) begin
      for (int k = 0; k < n; k++) begin
        expReads++;
        if (patErr(pat, k)) begin expBad = 1; expErr = 1; break; end
        if (ones(patByte(pat, k, blk)) < thr) begin expBad = 1; break; end
      end
    end
    blockNum = BW'(blk); largePage = lg;
    {chkLast, chkSecond, chkFirst} = flags;
    threshold = 4'(thr); noBbmQuirk = quirk; startReq = 1'b1;
    @(negedge clk);
    if (poke) begin
      blockNum = ~BW'(blk); largePage = ~lg; {chkLast, chkSecond, chkFirst} = ~flags;
      threshold = 4'(8 - thr); noBbmQuirk = ~quirk;
    end else startReq = 1'b0;
    if (!quirk) chk("R10 busy after start", int'(busy), 1);
    while (!seenDone && guard < 80) begin
      guard++;
      if (done) begin
        seenDone = 1;
      end else if (rdReq) begin
        reads++;
        if (reads <= n) begin
          chk("R3 R4 page order", int'(rdPage), expPg[reads-1]);
          chk("R2 marker column", int'(rdCol), lg ? 0 : 5);
        end
        lat = (blk + reads) % 3;
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          chk("R12 request held", int'(rdReq), 1);
          if (reads <= n) chk("R12 page stable", int'(rdPage), expPg[reads-1]);
        end
        rdAck = 1'b1; rdByte = patByte(pat, reads - 1, blk); rdErr = patErr(pat, reads - 1);
        @(negedge clk);
        rdAck = 1'b0; rdErr = 1'b0;
        chk("R12 request gap", int'(rdReq), 0);
      end else begin
        @(negedge clk);
      end
    end
    startReq = 1'b0;
    chk("R10 done seen", int'(seenDone), 1);
    chk("R4 R7 R8 read count", reads, expReads);
    chk("R6 R7 bad verdict", int'(isBad), int'(expBad));
    chk("R9 error flag", int'(rdErrFlag), int'(expErr));
    if (quirk) chk("R8 not busy", int'(busy), 0);
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
    chk("R10 verdict held", int'(isBad), int'(expBad));
    chk("R11 no restart", int'(busy), 0);
  endtask

  initial begin
    int run = 0;
    int thrTab[4] = '{0, 4, 7, 8};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 rdReq", int'(rdReq), 0);
    chk("R1 isBad", int'(isBad), 0);
    chk("R1 rdErrFlag", int'(rdErrFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(busy), 0);
    // R6 threshold boundary on 0xF7
    runCase(5, 1'b0, 3'b001, 7, 1'b0, 1, 1'b0);
    runCase(5, 1'b1, 3'b001, 8, 1'b0, 1, 1'b0);
    // sweep
    for (int lg = 0; lg < 2; lg++)
      for (int f = 0; f < 8; f++)
        for (int t = 0; t < 4; t++)
          for (int p = 0; p < 6; p++) begin
            runCase(run % 64, lg[0], 3'(f), thrTab[t], 1'b0, p, (run % 5) == 0);
            run++;
          end
    // R8 quirk bypass, including error patterns
    for (int f = 0; f < 8; f++)
      for (int p = 3; p < 6; p++)
        runCase(63 - f, f[0], 3'(f), 8, 1'b1, p, f == 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule